// File: doc/BRIEF.md
# Serial Byte Transmitter with Programmable Inter-Byte Gap

This block sends bytes on an asynchronous serial line and is controlled through a small word-wide register interface. A write to the data register sends one byte: a low start bit, eight data bits least significant first, then a high idle period before the next byte may start. All timing is counted in bit times. Each bit time is marked by an external one-cycle `bit_tick` pulse from a shared baud divider.

Two modes set the idle period. In single-byte mode, a control bit selects one or two stop bits. In block mode, software streams bytes back to back, and a gap register sets the idle time to (gap − 7) bit times, with a floor of one bit time. The gap register has no effect outside block mode. The idle period is latched when a byte is accepted.

The receive datapath is not part of this block. Only its software-visible end is here: a byte strobed in on `rx_valid` is held, a receive-ready flag is raised, and reading the data register returns the byte and clears the flag.

Top module: `gap_uart_tx`

Register map (`addr`):
- 0, control/status:
  - bit 0: transmit ready (read-only).
  - bit 1: receive ready (read-only).
  - bit 2: single stop bit select.
  - bit 3: block mode.
  - bit 4: overrun (sticky; cleared by writing 1 to it).
- 1, data.
- 2, gap: bits [7:0].
- 3: reads 0.

Bits [15:8] of the data and gap registers, and control bits [15:5], always read 0.

## Requirements
- R1: After reset, `tx_line` is 1, the control register reads 0x0001 (transmit ready set, everything else clear), and the gap register reads 0x0009.
- R2: A write to address 1 while transmit ready is 1 sends a frame. The frame is a start bit at 0, then `wdata[7:0]` least significant bit first, each bit lasting exactly one bit time. The line goes low on the first `bit_tick` after the write.
- R3: In single-byte mode (control bit 3 = 0), the idle period after the data bits is 1 bit time when control bit 2 is 1, and 2 bit times when it is 0. The gap register value has no effect.
- R4: In block mode (control bit 3 = 1), the idle period is (gap[7:0] − 7) bit times, and gap values below 8 give 1 bit time. At reset (value 9) this gives 2 bit times.
- R5: Transmit ready (control bit 0) drops in the cycle after an accepted write. It returns to 1 exactly (9 + idle) bit times after the start bit begins.
- R6: A data write while transmit ready is 0 has no effect on the frame in flight, and it sets the overrun bit (control bit 4). The overrun bit stays set until a control write with bit 4 = 1 clears it.
- R7: Bits [15:8] of the data and gap registers read 0 even after writing ones to them. Control bits [15:5] also read 0.
- R8: A one-cycle `rx_valid` pulse stores `rx_byte` and sets receive ready (control bit 1). A read of address 1 with `rd_en` returns the byte in bits [7:0] and clears receive ready.
- R9: `tx_line` is 1 at all times outside the start and data bits of a frame, including the whole idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on data register only) |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The hardest case to reach from the ports is a data write that lands in the middle of a frame. It must leave the shifting byte untouched while still recording overrun. The bench reaches this by issuing a second data write with a different pattern a few bit times after the falling start edge. It then rebuilds the transmitted byte from mid-bit samples and compares it with the first write. The gap boundary is covered by sweeping every gap value from 0 to 16 plus 255. The frame length is measured in cycles and compared with (9 + max(gap − 7, 1)) tick periods.

// File: rtl/gap_uart_pkg.sv
package gap_uart_pkg;
    localparam int REG_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_GAP  = 2'd2;

    localparam int C_TXRDY   = 0;
    localparam int C_RXRDY   = 1;
    localparam int C_ONESTOP = 2;
    localparam int C_BLOCK   = 3;
    localparam int C_OVR     = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_START,
        PH_DATA,
        PH_STOP
    } phase_e;
endpackage

// File: rtl/gap_uart_regs.sv
module gap_uart_regs
    import gap_uart_pkg::*;
#(
    parameter int GAP_W = 8,
    parameter int GAP_RST = 9,
    parameter int GAP_BIAS = 7,
    localparam int CW = GAP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              busy,
    output logic              load_req,
    output logic [CW-1:0]     stop_len,
    output logic [REG_W-1:0]  rdata
);
    typedef struct packed {
        logic [GAP_W-1:0]  gap;
        logic              one_stop;
        logic              block;
        logic              ovr;
        logic [BYTE_W-1:0] rxb;
        logic              rx_rdy;
    } regs_t;

    regs_t r_d, r_q;

    assign load_req = wr_en && (addr == A_DATA);

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == A_GAP)
            r_d.gap = wdata[GAP_W-1:0];
        if (wr_en && addr == A_CTRL) begin
            r_d.one_stop = wdata[C_ONESTOP];
            r_d.block    = wdata[C_BLOCK];
            if (wdata[C_OVR])
                r_d.ovr = 1'b0;
        end
        if (load_req && busy)
            r_d.ovr = 1'b1;
        if (rx_valid) begin
            r_d.rxb    = rx_byte;
            r_d.rx_rdy = 1'b1;
        end else if (rd_en && addr == A_DATA) begin
            r_d.rx_rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.gap      <= GAP_W'(GAP_RST);
            r_q.one_stop <= 1'b0;
            r_q.block    <= 1'b0;
            r_q.ovr      <= 1'b0;
            r_q.rxb      <= '0;
            r_q.rx_rdy   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (r_q.block) begin
            if (r_q.gap <= GAP_W'(GAP_BIAS))
                stop_len = CW'(1);
            else
                stop_len = CW'(r_q.gap) - CW'(GAP_BIAS);
        end else begin
            stop_len = r_q.one_stop ? CW'(1) : CW'(2);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[C_TXRDY]   = !busy;
                rdata[C_RXRDY]   = r_q.rx_rdy;
                rdata[C_ONESTOP] = r_q.one_stop;
                rdata[C_BLOCK]   = r_q.block;
                rdata[C_OVR]     = r_q.ovr;
            end
            A_DATA:  rdata[BYTE_W-1:0] = r_q.rxb;
            A_GAP:   rdata[GAP_W-1:0]  = r_q.gap;
            default: rdata = '0;
        endcase
    end

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && busy) |=> r_q.ovr);

    // R8
    rx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (r_q.rx_rdy && r_q.rxb == $past(rx_byte)));
endmodule

// File: rtl/gap_uart_frame.sv
module gap_uart_frame
    import gap_uart_pkg::*;
#(
    parameter int CW = 9,
    localparam int IW = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load_req,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic [CW-1:0]     stop_len,
    output logic              busy,
    output logic              tx_line
);
    typedef struct packed {
        phase_e            ph;
        logic [BYTE_W-1:0] byte_v;
        logic [IW-1:0]     idx;
        logic [CW-1:0]     len;
        logic [CW-1:0]     cnt;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        case (e_q.ph)
            PH_IDLE: if (load_req) begin
                e_d.ph     = PH_ARM;
                e_d.byte_v = load_byte;
                e_d.len    = stop_len;
            end
            PH_ARM: if (bit_tick)
                e_d.ph = PH_START;
            PH_START: if (bit_tick) begin
                e_d.ph  = PH_DATA;
                e_d.idx = '0;
            end
            PH_DATA: if (bit_tick) begin
                if (e_q.idx == IW'(BYTE_W - 1)) begin
                    e_d.ph  = PH_STOP;
                    e_d.cnt = e_q.len - CW'(1);
                end else begin
                    e_d.idx = e_q.idx + IW'(1);
                end
            end
            PH_STOP: if (bit_tick) begin
                if (e_q.cnt == '0)
                    e_d.ph = PH_IDLE;
                else
                    e_d.cnt = e_q.cnt - CW'(1);
            end
            default: e_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.ph     <= PH_IDLE;
            e_q.byte_v <= '0;
            e_q.idx    <= '0;
            e_q.len    <= CW'(1);
            e_q.cnt    <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy = (e_q.ph != PH_IDLE);

    always_comb begin
        case (e_q.ph)
            PH_START: tx_line = 1'b0;
            PH_DATA:  tx_line = e_q.byte_v[e_q.idx];
            default:  tx_line = 1'b1;
        endcase
    end

    // R6
    inflight_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && busy) |=> $stable(e_q.byte_v));

    // R5
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !busy) |=> busy);

    // R4
    gap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.ph == PH_STOP) |-> (e_q.len != '0 && e_q.cnt < e_q.len));
endmodule

// File: rtl/gap_uart_tx.sv
module gap_uart_tx
    import gap_uart_pkg::*;
#(
    parameter int GAP_W = 8,
    parameter int GAP_RST = 9,
    localparam int CW = GAP_W + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        tx_line
);
    logic          busy;
    logic          load_req;
    logic [CW-1:0] stop_len;

    gap_uart_regs #(
        .GAP_W   (GAP_W),
        .GAP_RST (GAP_RST),
        .GAP_BIAS(7)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .busy    (busy),
        .load_req(load_req),
        .stop_len(stop_len),
        .rdata   (rdata)
    );

    gap_uart_frame #(
        .CW(CW)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .load_req (load_req),
        .load_byte(wdata[BYTE_W-1:0]),
        .stop_len (stop_len),
        .busy     (busy),
        .tx_line  (tx_line)
    );

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);
endmodule

// File: tb/gap_uart_tx_tb.sv
module gap_uart_tx_tb;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_line;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    always #10 clk = ~clk;

    gap_uart_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_line(tx_line)
    );

    always @(negedge clk) begin
        tcnt = (tcnt + 1) % P;
        bit_tick = (tcnt == P - 1);
    end

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic rreg(input logic [1:0] a, input logic strobe,
                        output logic [15:0] v);
        @(negedge clk);
        addr = a; rd_en = strobe;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd0;
    endtask

    // Sends one byte, measures frame; optionally writes junk mid-frame.
    task automatic frame(input logic [7:0] b, input int n, input bit inject,
                         input string req);
        logic [7:0] got;
        int i;
        int wait_c;
        bit stop_ok;
        bit rdy_low;
        got = '0; stop_ok = 1'b1; rdy_low = 1'b0;
        wreg(2'd1, {8'hFF, b});
        wait_c = 0;
        while (tx_line !== 1'b0 && wait_c < 20) begin
            @(negedge clk);
            wait_c++;
        end
        i = 0;
        // i = 0 at the first negedge with the line low
        forever begin
            if (i > 0) @(negedge clk);
            wr_en = 1'b0; addr = 2'd0; wdata = '0;
            #1;
            if (i == 1 && rdata[0] == 1'b0) rdy_low = 1'b1;
            if (rdata[0] === 1'b1 || i > (9 + 300) * P) break;
            if (i >= P && i < 9 * P && (i % P) == P / 2)
                got[(i / P) - 1] = tx_line;
            if (i >= 9 * P && tx_line !== 1'b1) stop_ok = 1'b0;
            if (i == 0 && tx_line !== 1'b0) stop_ok = 1'b0;
            if (inject && i == 3 * P) begin
                wr_en = 1'b1; addr = 2'd1; wdata = {8'h00, ~b};
            end
            i++;
        end
        chk({req, " R2 byte"}, 32'(got), 32'(b));
        chk({req, " frame length R5"}, i, (9 + n) * P);
        chk({req, " R9 idle high"}, 32'(stop_ok), 1);
        chk({req, " R5 ready low"}, 32'(rdy_low), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 line", 32'(tx_line), 1);
        rreg(2'd0, 1'b0, v); chk("R1 ctrl", 32'(v), 32'h0001);
        rreg(2'd2, 1'b0, v); chk("R1 gap", 32'(v), 32'h0009);

        // R3: single mode, both stop settings, gap ignored
        for (int s = 0; s < 2; s++) begin
            wreg(2'd0, 16'(s << 2));
            for (int k = 0; k < 6; k++)
                frame(pats[k], s ? 1 : 2, 1'b0, "R3 single");
        end
        wreg(2'd2, 16'd3);
        wreg(2'd0, 16'h0004);
        frame(8'h3C, 1, 1'b0, "R3 gap ignored");
        wreg(2'd2, 16'd40);
        wreg(2'd0, 16'h0000);
        frame(8'hC3, 2, 1'b0, "R3 gap ignored");

        // R4: block mode gap sweep
        wreg(2'd0, 16'h0008);
        for (int g = 0; g <= 16; g++) begin
            wreg(2'd2, 16'(g));
            frame(8'(g * 37 + 5), (g < 8) ? 1 : g - 7, 1'b0, "R4 block");
        end
        wreg(2'd2, 16'd255);
        frame(8'h96, 248, 1'b0, "R4 block max");

        // R6: write during frame
        wreg(2'd2, 16'd9);
        frame(8'hB2, 2, 1'b1, "R6 overrun");
        rreg(2'd0, 1'b0, v); chk("R6 ovr set", 32'(v[4]), 1);
        wreg(2'd0, 16'h0008);
        rreg(2'd0, 1'b0, v); chk("R6 ovr sticky", 32'(v[4]), 1);
        wreg(2'd0, 16'h0018);
        rreg(2'd0, 1'b0, v); chk("R6 ovr cleared", 32'(v[4]), 0);
        chk("R6 line idle", 32'(tx_line), 1);

        // R7: reserved bits
        wreg(2'd2, 16'hFFFF);
        rreg(2'd2, 1'b0, v); chk("R7 gap", 32'(v), 32'h00FF);
        wreg(2'd0, 16'hFFEF);
        rreg(2'd0, 1'b0, v); chk("R7 ctrl", 32'(v), 32'h000D);

        // R8: receive path
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h6E;
        @(negedge clk); rx_valid = 1'b0; rx_byte = '0;
        rreg(2'd0, 1'b0, v); chk("R8 rx ready", 32'(v[1]), 1);
        rreg(2'd1, 1'b1, v); chk("R8 rx byte", 32'(v), 32'h006E);
        rreg(2'd0, 1'b0, v); chk("R8 rx cleared", 32'(v[1]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule